// File: doc/BRIEF.md
# CAN Bit Sampler with Hard Resynchronisation

This block turns an oversampled CAN receive line into a stream of sampled bits. The system clock runs many times faster than the bus. The block tracks where each bit time falls, picks one clock per bit at a programmable sample position, and emits a single-cycle strobe that carries the level it saw there. The bit-time length is given in clock cycles with four fractional bits, so a clock that does not divide evenly into the bit rate still yields correct sample positions over a whole frame.

Two bit-time lengths are held at once: a nominal one for arbitration and a fast one for a data phase. Downstream frame logic pulses `go_fast` to enter the fast rate and `go_nominal` to leave it. Every recessive-to-dominant edge seen while receiving restarts the timing reference. A fast switch also restarts the reference, at the cycle of the pulse. Stuffed bits are not recognised here. Every bit time produces a strobe and advances the bit index. A `frame_end` pulse from the frame parser returns the block to idle, where it waits for the next dominant level.

The strobe output has no ready input and cannot be held back. Bus timing is fixed, so the consumer must accept each `bit_valid` cycle as it comes.

Top module: `can_bit_sampler`

## Requirements
- R1: After reset the block is idle (`rx_active` = 0), `bit_valid` is 0 and `bit_index` is 0.
- R2: While idle, a recessive (1) line keeps the block idle and produces no strobe. The first synchronised low level starts reception, and that cycle becomes the timing reference for bit 0. The line passes through `SYNC_STAGES` flops, so with the default of 2 the reference cycle comes two clocks after the line falls. `bit_valid` only ever pulses while `rx_active` is 1.
- R3: The sample offset in Q4 clocks is floor(width_q4 × `sp_pct` / 100). Here width_q4 is the selected bit width and `sp_pct` is a percentage from 0 to 100.
- R4: Take bit k as counted from the latest reference, with k = 0 at the reference itself. Its strobe decision falls floor((offset_q4 + k × width_q4) / 16) clocks after the reference cycle. `bit_valid` is then registered one clock later. The fractional part carries forward, so no error builds up across bits.
- R5: While receiving, a synchronised 1-to-0 transition makes that cycle the new reference. The next strobe lands the sample offset later, and the bit index continues from where it was.
- R6: `bit_index` is the index of the bit carried by the current strobe. It is 0 for the first bit after a start and rises by one on every strobe, whatever the bit's value.
- R7: A `go_fast` pulse while receiving selects `fast_bw_q4` and makes its cycle a new reference. The next strobe decision falls floor((fast_width_q4 + fast_offset_q4) / 16) clocks after the pulse cycle, and later bits are spaced at the fast width.
- R8: A `go_nominal` pulse selects `nom_bw_q4` for all later steps and resynchronisations.
- R9: `frame_end` has priority over everything else. It returns the block to idle, cancels any pending strobe, clears the bit counter and restores the nominal width. The next reception therefore starts at index 0 at the nominal rate.
- R10: `bit_value` is the synchronised line level in the decision cycle, with 0 meaning dominant.
- R11: If a falling edge and `go_fast` fall in the same cycle, the edge sets the phase. The next strobe comes one fast sample offset after that cycle, and the fast width still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Raw CAN receive line (0 = dominant) |
| nom_bw_q4 | input | BW_W | Nominal bit width in clocks, 4 fractional bits (at least 2 clocks) |
| fast_bw_q4 | input | BW_W | Fast bit width in clocks, 4 fractional bits (at least 2 clocks) |
| sp_pct | input | PCT_W | Sample position as a percentage of the bit width, 0 to 100 |
| go_fast | input | 1 | Pulse: select the fast width and re-reference |
| go_nominal | input | 1 | Pulse: select the nominal width |
| frame_end | input | 1 | Pulse: return to idle and clear the bit counter |
| bit_valid | output | 1 | Single-cycle strobe, one per bit time |
| bit_value | output | 1 | Sampled level carried by the strobe |
| bit_index | output | IDX_W | Index of the strobed bit since the frame start |
| rx_active | output | 1 | High while receiving a frame |

## Verification
The bench builds the block with its default parameters: a two-flop synchroniser, 16-bit Q4 widths and a 10-bit index. At the ports it drives widths of 10, 10.5 and 5 clocks, with sample positions of 70 % and 25 %. The 10.5-clock case makes the fractional offset and its carry visible within eight bits. The 5-clock fast width, at half the nominal width, separates fast and nominal spacing within a few bits. Edges are placed off the ideal grid so that a resynchronisation moves the strobes by a measurable number of clocks.

// File: rtl/can_bs_pkg.sv
`timescale 1ns/1ps
package can_bs_pkg;
  // Receive state: waiting for a dominant level, or timing bits of a frame.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RX   = 1'b1
  } rx_state_e;

  // One whole clock in Q4 fixed point.
  localparam int unsigned Q4_ONE = 16;
endpackage

// File: rtl/can_bs_sync.sv
`timescale 1ns/1ps
// Brings the asynchronous bus line into the clock domain and flags 1->0 edges.
module can_bs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rx_s,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q[0] <= rx_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign rx_s = chain_q[STAGES-1];
  assign fall = prev_q & ~rx_s;
endmodule

// File: rtl/can_bs_rate.sv
`timescale 1ns/1ps
// Keeps the nominal/fast selection and derives the sample offset for the
// width that applies from this cycle on.
module can_bs_rate #(
  parameter int BW_W  = 16,
  parameter int PCT_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BW_W-1:0] nom_bw,
  input  logic [BW_W-1:0] fast_bw,
  input  logic [PCT_W-1:0] pct,
  input  logic            sel_fast,
  input  logic            sel_nom,
  input  logic            clear,
  output logic [BW_W-1:0] bw_o,
  output logic [BW_W-1:0] sp_o
);
  localparam int PW = BW_W + PCT_W;

  logic          fast_q, fast_d;
  logic [PW-1:0] prod, quo;

  // Clear wins, then a fast request, then a nominal request.
  always_comb begin
    fast_d = fast_q;
    if (clear)         fast_d = 1'b0;
    else if (sel_fast) fast_d = 1'b1;
    else if (sel_nom)  fast_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fast_q <= 1'b0;
    else        fast_q <= fast_d;
  end

  assign bw_o = fast_d ? fast_bw : nom_bw;

  always_comb begin
    prod = PW'(bw_o) * PW'(pct);
    quo  = prod / PW'(100);
    sp_o = quo[BW_W-1:0];
  end
endmodule

// File: rtl/can_bs_phase.sv
`timescale 1ns/1ps
// Phase accumulator. phase_q holds, in Q4, the distance from the start of the
// current cycle to the next sample instant. A cycle whose distance is below one
// whole clock is the sample cycle.
module can_bs_phase
  import can_bs_pkg::*;
#(
  parameter int BW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            ref_now,
  input  logic            hop,
  input  logic [BW_W-1:0] bw,
  input  logic [BW_W-1:0] sp,
  output logic            take
);
  localparam int PH_W = BW_W + 1;
  localparam logic [PH_W-1:0] ONE = PH_W'(Q4_ONE);

  logic [PH_W-1:0] phase_q, phase_d, p_eff, bw_x, sp_x;

  assign bw_x = {1'b0, bw};
  assign sp_x = {1'b0, sp};

  // An edge starts the bit at this cycle; a rate hop treats this cycle as the
  // start of the bit before the next one.
  always_comb begin
    if (ref_now)  p_eff = sp_x;
    else if (hop) p_eff = bw_x + sp_x;
    else          p_eff = phase_q;
  end

  assign take = run && (p_eff < ONE);

  always_comb begin
    if (!run)      phase_d = '0;
    else if (take) phase_d = p_eff + bw_x - ONE;
    else           phase_d = p_eff - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/can_bit_sampler.sv
`timescale 1ns/1ps
// Top: idle/receive control, bit counter and strobe registers.
module can_bit_sampler
  import can_bs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BW_W        = 16,
  parameter int PCT_W       = 7,
  parameter int IDX_W       = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [BW_W-1:0]  nom_bw_q4,
  input  logic [BW_W-1:0]  fast_bw_q4,
  input  logic [PCT_W-1:0] sp_pct,
  input  logic             go_fast,
  input  logic             go_nominal,
  input  logic             frame_end,
  output logic             bit_valid,
  output logic             bit_value,
  output logic [IDX_W-1:0] bit_index,
  output logic             rx_active
);
  rx_state_e        state_q, state_d;
  logic             rx_s, rx_fall;
  logic [BW_W-1:0]  bw_cur, sp_cur;
  logic             start, resync, run, hop, take;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q, value_q;
  logic [IDX_W-1:0] index_q;

  can_bs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .rx_i (rx_i),
    .rx_s (rx_s),
    .fall (rx_fall)
  );

  can_bs_rate #(.BW_W(BW_W), .PCT_W(PCT_W)) u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .nom_bw  (nom_bw_q4),
    .fast_bw (fast_bw_q4),
    .pct     (sp_pct),
    .sel_fast(go_fast),
    .sel_nom (go_nominal),
    .clear   (frame_end),
    .bw_o    (bw_cur),
    .sp_o    (sp_cur)
  );

  // Idle waits for a level; receiving reacts to 1->0 transitions only.
  assign start  = (state_q == ST_IDLE) && !rx_s && !frame_end;
  assign resync = (state_q == ST_RX) && rx_fall && !frame_end;
  assign run    = !frame_end && ((state_q == ST_RX) || start);
  assign hop    = go_fast && (state_q == ST_RX);

  can_bs_phase #(.BW_W(BW_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .ref_now(start | resync),
    .hop    (hop),
    .bw     (bw_cur),
    .sp     (sp_cur),
    .take   (take)
  );

  always_comb begin
    state_d = state_q;
    if (frame_end)  state_d = ST_IDLE;
    else if (start) state_d = ST_RX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      valid_q <= 1'b0;
      value_q <= 1'b1;
      index_q <= '0;
    end else begin
      state_q <= state_d;
      valid_q <= take;
      if (frame_end) begin
        idx_q <= '0;
      end else if (take) begin
        idx_q   <= idx_q + 1'b1;
        index_q <= idx_q;
        value_q <= rx_s;
      end
    end
  end

  assign bit_valid = valid_q;
  assign bit_value = value_q;
  assign bit_index = index_q;
  assign rx_active = (state_q == ST_RX);
endmodule

// File: rtl/can_bit_sampler_chk.sv
`timescale 1ns/1ps
module can_bit_sampler_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic [IDX_W-1:0] bit_index,
  input logic             rx_active,
  input logic             frame_end,
  input logic             go_fast,
  input logic             rx_s,
  input logic             rx_fall
);
  a_r9_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!rx_active && !bit_valid));

  a_r2_idle_holds_on_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_active && rx_s) |=> !rx_active);

  a_r2_strobe_only_when_active: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> rx_active);

  a_r6_index_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_index) |-> bit_valid);

  a_r7_hop_defers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (go_fast && rx_active && !rx_fall && !frame_end) |=> !bit_valid);
endmodule

bind can_bit_sampler can_bit_sampler_chk #(.IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_valid(bit_valid),
  .bit_index(bit_index),
  .rx_active(rx_active),
  .frame_end(frame_end),
  .go_fast  (go_fast),
  .rx_s     (rx_s),
  .rx_fall  (rx_fall)
);

// File: tb/can_bit_sampler_bench.sv
`timescale 1ns/1ps
module can_bit_sampler_bench;
  localparam int BW_W  = 16;
  localparam int PCT_W = 7;
  localparam int IDX_W = 10;
  localparam int LAT   = 3;               // drive negedge -> reference cycle
  localparam logic [7:0] PAT = 8'b10010110; // bit n = PAT[n]

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, go_fast = 1'b0, go_nom = 1'b0, frame_end = 1'b0;
  logic [BW_W-1:0]  nom_bw = 16'd160, fast_bw = 16'd80;
  logic [PCT_W-1:0] sp_pct = 7'd70;
  logic             bit_valid, bit_value, rx_active;
  logic [IDX_W-1:0] bit_index;

  always #2 clk = ~clk;

  can_bit_sampler #(.SYNC_STAGES(2), .BW_W(BW_W), .PCT_W(PCT_W), .IDX_W(IDX_W)) u_can_bit_sampler (
    .clk(clk), .rst_n(rst_n), .rx_i(rx),
    .nom_bw_q4(nom_bw), .fast_bw_q4(fast_bw), .sp_pct(sp_pct),
    .go_fast(go_fast), .go_nominal(go_nom), .frame_end(frame_end),
    .bit_valid(bit_valid), .bit_value(bit_value), .bit_index(bit_index),
    .rx_active(rx_active)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int   cap_cyc [64];
  logic cap_val [64];
  int   cap_idx [64];
  int   n_cap = 0;

  always @(posedge clk) begin
    #1;
    if (rst_n && bit_valid && n_cap < 64) begin
      cap_cyc[n_cap] = cyc;
      cap_val[n_cap] = bit_value;
      cap_idx[n_cap] = int'(bit_index);
      n_cap++;
    end
  end

  function automatic int spq(input int bw, input int pct);
    return bw * pct / 100;
  endfunction

  function automatic int jpos(input int sp, input int bw, input int n);
    return (sp + bw * n) / 16;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_bit(input int k, input string req, input int ecyc, input logic eval, input int eidx);
    if (k >= n_cap) chk(1'b0, {req, " strobe count"}, n_cap, k + 1);
    else begin
      chk(cap_cyc[k] == ecyc, {req, " time"}, cap_cyc[k], ecyc);
      chk(cap_val[k] == eval, {req, " value"}, int'(cap_val[k]), int'(eval));
      chk(cap_idx[k] == eidx, {req, " index"}, cap_idx[k], eidx);
    end
  endtask

  task automatic pulse_end();
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
    @(negedge clk);
  endtask

  // R1: reset state
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_active == 1'b0, "R1 idle", int'(rx_active), 0);
    chk(bit_valid == 1'b0, "R1 valid", int'(bit_valid), 0);
    chk(bit_index == '0, "R1 index", int'(bit_index), 0);
  endtask

  // R2: recessive line keeps the block idle
  task automatic t_idle_high();
    n_cap = 0;
    rx = 1'b1;
    repeat (40) @(negedge clk);
    chk(n_cap == 0, "R2 no strobe while idle", n_cap, 0);
    chk(rx_active == 1'b0, "R2 stays idle", int'(rx_active), 0);
  endtask

  // R2, R4, R6, R10: integer width, mixed bit pattern
  task automatic t_basic();
    int c0;
    n_cap = 0;
    c0 = cyc;
    for (int k = 0; k < 100; k++) begin
      rx = (k < 80) ? PAT[k/10] : 1'b1;
      @(negedge clk);
    end
    for (int n = 0; n < 8; n++)
      chk_bit(n, "R4/R6/R10", c0 + LAT + jpos(spq(160, 70), 160, n), PAT[n], n);
    pulse_end();
    chk(rx_active == 1'b0, "R9 idle after end", int'(rx_active), 0);
  endtask

  // R3, R4: fractional width keeps its remainder; other sample position
  task automatic t_frac();
    int c0;
    nom_bw = 16'd168;
    n_cap = 0;
    c0 = cyc;
    for (int k = 0; k < 100; k++) begin
      rx = (k < 10) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    for (int n = 0; n < 8; n++)
      chk_bit(n, "R3/R4 fractional", c0 + LAT + jpos(spq(168, 70), 168, n), (n == 0) ? 1'b0 : 1'b1, n);
    pulse_end();
    nom_bw = 16'd160;
    sp_pct = 7'd25;
    n_cap = 0;
    c0 = cyc;
    for (int k = 0; k < 30; k++) begin
      rx = (k < 10) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    chk_bit(0, "R3 pct25", c0 + LAT + jpos(spq(160, 25), 160, 0), 1'b0, 0);
    chk_bit(1, "R3 pct25", c0 + LAT + jpos(spq(160, 25), 160, 1), 1'b1, 1);
    pulse_end();
    sp_pct = 7'd70;
  endtask

  // R5: an edge off the grid moves the reference
  task automatic t_resync();
    int c0, x;
    n_cap = 0;
    c0 = cyc;
    x = c0 + LAT;
    for (int k = 0; k < 60; k++) begin
      rx = (k < 10) ? 1'b0 : (k < 23) ? 1'b1 : (k < 33) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    chk_bit(0, "R5", x + 7, 1'b0, 0);
    chk_bit(1, "R5", x + 17, 1'b1, 1);
    chk_bit(2, "R5 resync", x + 23 + 7, 1'b0, 2);
    chk_bit(3, "R5 resync", x + 23 + 17, 1'b1, 3);
    pulse_end();
  endtask

  // R7, R8: fast hop, then nominal with an edge
  task automatic t_fast();
    int c0;
    n_cap = 0;
    c0 = cyc;
    for (int k = 0; k < 80; k++) begin
      rx      = (k < 10) ? 1'b0 : (k >= 44 && k < 54) ? 1'b0 : 1'b1;
      go_fast = (k == 25);
      go_nom  = (k == 44);
      @(negedge clk);
    end
    go_fast = 1'b0;
    go_nom  = 1'b0;
    chk_bit(0, "R7 pre", c0 + LAT + 7, 1'b0, 0);
    chk_bit(1, "R7 pre", c0 + LAT + 17, 1'b1, 1);
    chk_bit(2, "R7 hop", c0 + 26 + jpos(80 + spq(80, 70), 80, 0), 1'b1, 2);
    chk_bit(3, "R7 fast", c0 + 26 + jpos(80 + spq(80, 70), 80, 1), 1'b1, 3);
    chk_bit(4, "R7 fast", c0 + 26 + jpos(80 + spq(80, 70), 80, 2), 1'b1, 4);
    chk_bit(5, "R8 nominal", c0 + 44 + LAT + 7, 1'b0, 5);
    chk_bit(6, "R8 nominal", c0 + 44 + LAT + 17, 1'b1, 6);
    pulse_end();
  endtask

  // R11: edge and fast pulse in the same cycle
  task automatic t_prio();
    int c0, x;
    n_cap = 0;
    c0 = cyc;
    x = c0 + 30 + LAT;
    for (int k = 0; k < 60; k++) begin
      rx      = (k < 10) ? 1'b0 : (k >= 30 && k < 40) ? 1'b0 : 1'b1;
      go_fast = (k == 32);
      @(negedge clk);
    end
    go_fast = 1'b0;
    chk_bit(2, "R11 nominal before", c0 + LAT + 27, 1'b1, 2);
    chk_bit(3, "R11 edge wins", x + jpos(spq(80, 70), 80, 0), 1'b0, 3);
    chk_bit(4, "R11 fast width", x + jpos(spq(80, 70), 80, 1), 1'b0, 4);
    chk_bit(5, "R11 fast width", x + jpos(spq(80, 70), 80, 2), 1'b1, 5);
    pulse_end();
  endtask

  // R9: end in fast mode cancels, clears index, restores nominal
  task automatic t_end();
    int c0, first;
    n_cap = 0;
    c0 = cyc;
    for (int k = 0; k < 100; k++) begin
      rx        = (k < 10) ? 1'b0 : (k >= 60 && k < 70) ? 1'b0 : 1'b1;
      go_fast   = (k == 20);
      frame_end = (k == 40);
      @(negedge clk);
    end
    go_fast = 1'b0;
    frame_end = 1'b0;
    first = -1;
    for (int i = n_cap - 1; i >= 0; i--)
      if (cap_cyc[i] > c0 + 41) first = i;
    if (first < 0) chk(1'b0, "R9 restart strobe", 0, 1);
    else begin
      chk_bit(first, "R9 restart", c0 + 60 + LAT + 7, 1'b0, 0);
      chk_bit(first + 1, "R9 nominal after end", c0 + 60 + LAT + 17, 1'b1, 1);
    end
    pulse_end();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_high();
    t_basic();
    t_frac();
    t_resync();
    t_fast();
    t_prio();
    t_end();
    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule